// File: doc/BRIEF.md
# Fused Dependent-Pair Integer Execute Unit

This unit executes one fused macro-op per cycle. A macro-op carries a head operation and a tail operation that depends on it. The tail consumes the head's result. Both operations finish in the same execute cycle, because the tail does not wait on any forwarding path. The head result comes from an ordinary two-input ALU. In parallel, a three-input collapsed path computes the tail result directly from the head's own operands plus one further value.

A second register stage follows the execute cycle and stands for the writeback slot. Results, their destination tags and their write strobes appear a fixed two cycles after the macro-op is accepted. If the tail is a condition test on the head result, the branch outcome is produced in the same pass. A pair that the collapsed datapath cannot carry is flagged as illegal and writes nothing.

Top module: `fused_pair_alu`

## Requirements
- R1: While reset is low, `in_ready`, `out_valid`, both write strobes, `out_br_taken` and `out_illegal` are low. After reset is released, `in_ready` is high from the next cycle on.
- R2: A macro-op accepted at a rising edge (`in_valid` and `in_ready` both high) has its outputs valid after the following rising edge, exactly two edges later, and not after the first. One macro-op can be accepted every cycle, and results then emerge on consecutive cycles.
- R3: Head operation codes are 0 add, 1 subtract (first minus second), 2 AND, 3 OR and 4 XOR. The first head operand is `in_src_a`. The second is `in_src_b` when `in_head_use_imm` is 0; when it is 1, the second is the sign-extended `in_imm`.
- R4: The tail result is the head result combined with one other operand. That operand is chosen by `in_tail_src`: 0 selects `in_src_a`, 1 selects `in_src_b`, 2 selects `in_src_c` and 3 selects the sign-extended immediate. Tail codes are 0 add, 2 AND, 3 OR and 4 XOR. All arithmetic wraps modulo 2^W.
- R5: Each result is returned with its own destination tag. `out_head_we` follows `in_head_wen` and `out_tail_we` follows `in_tail_wen` for a legal macro-op, so a pair can write two distinct destinations.
- R6: Tail codes 8, 9 and 10 are condition tests on the head result: 8 means zero, 9 means non-zero and 10 means negative as a signed value. `out_br_taken` gives the outcome. A test tail never raises `out_tail_we`, and the head may still be written.
- R7: A head code above 4, or a tail code outside {0,2,3,4,8,9,10} (subtract included), raises `out_illegal`. It also forces both write strobes and `out_br_taken` low.
- R8: A pair may read at most two distinct source registers. Selecting `in_src_c` for the tail while the head reads `in_src_b` (`in_head_use_imm` = 0) is illegal and is treated as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Macro-op offered |
| in_ready | output | 1 | Unit can accept a macro-op |
| in_head_op | input | 4 | Head operation code |
| in_tail_op | input | 4 | Tail operation or test code |
| in_head_use_imm | input | 1 | Head second operand is the immediate |
| in_tail_src | input | 2 | Selects the tail's non-head operand |
| in_src_a | input | W | First register operand |
| in_src_b | input | W | Second register operand |
| in_src_c | input | W | Tail-only register operand |
| in_imm | input | IMM_W | Immediate, sign-extended |
| in_head_tag | input | TAG_W | Head destination tag |
| in_tail_tag | input | TAG_W | Tail destination tag |
| in_head_wen | input | 1 | Head result is to be written |
| in_tail_wen | input | 1 | Tail result is to be written |
| out_valid | output | 1 | Writeback slot holds a macro-op |
| out_head_we | output | 1 | Head write strobe |
| out_head_tag | output | TAG_W | Head destination tag |
| out_head_data | output | W | Head result |
| out_tail_we | output | 1 | Tail write strobe |
| out_tail_tag | output | TAG_W | Tail destination tag |
| out_tail_data | output | W | Tail result (zero for a test tail) |
| out_br_taken | output | 1 | Condition-test outcome |
| out_illegal | output | 1 | Pair rejected |

## Verification
Subtract heads feeding add tails are the main target. The bench drives operands that carry across the whole word. A collapsed adder that dropped the carry-in or misaligned the carry vector would return a tail off by one or by a power of two. Zero, non-zero and negative head results exercise each test code, so that inverted or swapped tests show a wrong taken flag. Each rejected case (a bad head code, a subtract tail, an unused code, and the three-register pairing) is checked for stray writes. Back-to-back issue catches a design whose stages lose or duplicate a macro-op, or whose outputs appear one cycle early.

// File: rtl/fpair_pkg.sv
// Shared operation codes and operand-select codes for the fused-pair unit.
// Assumes 4-bit operation fields and a 2-bit tail operand select.
package fpair_pkg;
    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_SUB = 4'd1;
    localparam logic [3:0] OP_AND = 4'd2;
    localparam logic [3:0] OP_OR  = 4'd3;
    localparam logic [3:0] OP_XOR = 4'd4;
    localparam logic [3:0] OP_TZ  = 4'd8;   // test head result == 0
    localparam logic [3:0] OP_TNZ = 4'd9;   // test head result != 0
    localparam logic [3:0] OP_TLT = 4'd10;  // test head result < 0

    localparam logic [1:0] SEL_A   = 2'd0;
    localparam logic [1:0] SEL_B   = 2'd1;
    localparam logic [1:0] SEL_C   = 2'd2;
    localparam logic [1:0] SEL_IMM = 2'd3;
endpackage

// File: rtl/fpair_decode.sv
// Classifies a head/tail pair and decides whether the collapsed datapath
// can carry it. Purely combinational; assumes codes from fpair_pkg.
module fpair_decode
    import fpair_pkg::*;
(
    input  logic [3:0] head_op,
    input  logic [3:0] tail_op,
    input  logic       head_use_imm,
    input  logic [1:0] tail_src,
    output logic       legal,
    output logic       head_arith,
    output logic       head_sub,
    output logic       tail_add,
    output logic       tail_test
);
    logic head_ok;
    logic tail_ok;
    logic regs_ok;

    // Legality of each half and of the register-count limit.
    always_comb begin
        head_ok    = (head_op <= OP_XOR);
        tail_test  = (tail_op == OP_TZ) || (tail_op == OP_TNZ) || (tail_op == OP_TLT);
        tail_ok    = (tail_op == OP_ADD) || (tail_op == OP_AND) || (tail_op == OP_OR) ||
                     (tail_op == OP_XOR) || tail_test;
        regs_ok    = !((tail_src == SEL_C) && !head_use_imm);
        legal      = head_ok && tail_ok && regs_ok;
        head_arith = (head_op == OP_ADD) || (head_op == OP_SUB);
        head_sub   = (head_op == OP_SUB);
        tail_add   = (tail_op == OP_ADD);
    end
endmodule

// File: rtl/fpair_head_alu.sv
// Conventional two-input ALU producing the head result.
// Assumes the opcode is legal; unknown codes return zero.
module fpair_head_alu
    import fpair_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res
);
    // Select the head operation.
    always_comb begin
        case (op)
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/fpair_collapse.sv
// Three-input collapsed tail path. For an arithmetic head feeding an add
// tail it sums the head's own operands and the tail operand through a
// carry-save layer, without waiting for the head sum. Logic tails and
// condition tests use the head result, which is ready in the same cycle.
module fpair_collapse
    import fpair_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   tail_op,
    input  logic         head_arith,
    input  logic         head_sub,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] other,
    input  logic [W-1:0] head_res,
    output logic [W-1:0] tail_res,
    output logic         taken
);
    logic [W-1:0] y_in;
    logic [W-1:0] csa_sum;
    logic [W-1:0] csa_cry;
    logic [W-1:0] fused_sum;

    // Invert the head's second operand for subtract (carry-in supplies +1).
    always_comb y_in = head_sub ? ~opb : opb;

    // Carry-save layer, one full adder per bit.
    for (genvar i = 0; i < W; i++) begin : g_csa
        assign csa_sum[i] = opa[i] ^ y_in[i] ^ other[i];
        assign csa_cry[i] = (opa[i] & y_in[i]) | (opa[i] & other[i]) | (y_in[i] & other[i]);
    end

    // Final carry-propagate add of the carry-save pair.
    always_comb fused_sum = csa_sum + {csa_cry[W-2:0], 1'b0} + {{(W-1){1'b0}}, head_sub};

    // Tail result and condition outcome.
    always_comb begin
        taken = 1'b0;
        case (tail_op)
            OP_ADD:  tail_res = head_arith ? fused_sum : (head_res + other);
            OP_AND:  tail_res = head_res & other;
            OP_OR:   tail_res = head_res | other;
            OP_XOR:  tail_res = head_res ^ other;
            OP_TZ:   begin tail_res = '0; taken = (head_res == '0); end
            OP_TNZ:  begin tail_res = '0; taken = (head_res != '0); end
            OP_TLT:  begin tail_res = '0; taken = head_res[W-1]; end
            default: tail_res = '0;
        endcase
    end
endmodule

// File: rtl/fused_pair_alu.sv
// Fused dependent-pair execute unit. Cycle 1 computes head and tail
// results together; cycle 2 is the writeback slot. Latency is fixed at
// two edges and one macro-op is accepted per cycle. Assumes W > IMM_W.
module fused_pair_alu
    import fpair_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [3:0]       in_head_op,
    input  logic [3:0]       in_tail_op,
    input  logic             in_head_use_imm,
    input  logic [1:0]       in_tail_src,
    input  logic [W-1:0]     in_src_a,
    input  logic [W-1:0]     in_src_b,
    input  logic [W-1:0]     in_src_c,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [TAG_W-1:0] in_head_tag,
    input  logic [TAG_W-1:0] in_tail_tag,
    input  logic             in_head_wen,
    input  logic             in_tail_wen,
    output logic             out_valid,
    output logic             out_head_we,
    output logic [TAG_W-1:0] out_head_tag,
    output logic [W-1:0]     out_head_data,
    output logic             out_tail_we,
    output logic [TAG_W-1:0] out_tail_tag,
    output logic [W-1:0]     out_tail_data,
    output logic             out_br_taken,
    output logic             out_illegal
);
    localparam int EXT_W = W - IMM_W;

    logic             accept;
    logic [W-1:0]     imm_x;
    logic [W-1:0]     head_b;
    logic [W-1:0]     tail_other;
    logic             dec_legal, dec_head_arith, dec_head_sub, dec_tail_add, dec_tail_test;
    logic [W-1:0]     head_res;
    logic [W-1:0]     tail_res;
    logic             tail_taken;

    logic             s1_valid, s1_legal, s1_test, s1_taken, s1_hwen, s1_twen;
    logic [W-1:0]     s1_head, s1_tail;
    logic [TAG_W-1:0] s1_htag, s1_ttag;

    // Ready rises one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Operand steering for head and tail.
    always_comb begin
        accept = in_valid && in_ready;
        imm_x  = {{EXT_W{in_imm[IMM_W-1]}}, in_imm};
        head_b = in_head_use_imm ? imm_x : in_src_b;
        case (in_tail_src)
            SEL_A:   tail_other = in_src_a;
            SEL_B:   tail_other = in_src_b;
            SEL_C:   tail_other = in_src_c;
            default: tail_other = imm_x;
        endcase
    end

    fpair_decode u_dec (
        .head_op      (in_head_op),
        .tail_op      (in_tail_op),
        .head_use_imm (in_head_use_imm),
        .tail_src     (in_tail_src),
        .legal        (dec_legal),
        .head_arith   (dec_head_arith),
        .head_sub     (dec_head_sub),
        .tail_add     (dec_tail_add),
        .tail_test    (dec_tail_test)
    );

    fpair_head_alu #(.W(W)) u_head (
        .op  (in_head_op),
        .opa (in_src_a),
        .opb (head_b),
        .res (head_res)
    );

    fpair_collapse #(.W(W)) u_tail (
        .tail_op    (in_tail_op),
        .head_arith (dec_head_arith),
        .head_sub   (dec_head_sub),
        .opa        (in_src_a),
        .opb        (head_b),
        .other      (tail_other),
        .head_res   (head_res),
        .tail_res   (tail_res),
        .taken      (tail_taken)
    );

    // Execute stage register: captures both results in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0; s1_legal <= 1'b0; s1_test <= 1'b0; s1_taken <= 1'b0;
            s1_hwen  <= 1'b0; s1_twen  <= 1'b0;
            s1_head  <= '0;   s1_tail  <= '0;   s1_htag  <= '0;   s1_ttag <= '0;
        end else begin
            s1_valid <= accept;
            s1_legal <= dec_legal;
            s1_test  <= dec_tail_test;
            s1_taken <= tail_taken;
            s1_hwen  <= in_head_wen;
            s1_twen  <= in_tail_wen;
            s1_head  <= head_res;
            s1_tail  <= tail_res;
            s1_htag  <= in_head_tag;
            s1_ttag  <= in_tail_tag;
        end
    end

    // Writeback stage register: strobes gated by legality and test kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0; out_head_we  <= 1'b0; out_tail_we <= 1'b0;
            out_br_taken <= 1'b0; out_illegal  <= 1'b0;
            out_head_tag <= '0;   out_tail_tag <= '0;
            out_head_data <= '0;  out_tail_data <= '0;
        end else begin
            out_valid     <= s1_valid;
            out_head_we   <= s1_valid && s1_legal && s1_hwen;
            out_tail_we   <= s1_valid && s1_legal && s1_twen && !s1_test;
            out_br_taken  <= s1_valid && s1_legal && s1_test && s1_taken;
            out_illegal   <= s1_valid && !s1_legal;
            out_head_tag  <= s1_htag;
            out_tail_tag  <= s1_ttag;
            out_head_data <= s1_head;
            out_tail_data <= s1_test ? '0 : s1_tail;
        end
    end

    // Assertions guarding the pipeline and the collapsed path.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && in_ready, 2));

    assert_illegal_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_head_we && !out_tail_we && !out_br_taken));

    assert_test_no_tail_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_br_taken |-> (out_valid && !out_tail_we));

    assert_strobe_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_head_we || out_tail_we) |-> out_valid);

    // Collapsed three-input sum must match the two-step reference.
    always_ff @(posedge clk) begin
        if (rst_n && dec_legal && dec_head_arith && dec_tail_add) begin
            assert_collapse_match_R4: assert (tail_res == head_res + tail_other);
        end
    end
endmodule

// File: tb/sim_fused_pair_alu.sv
// Directed bench for fused_pair_alu: one task per scenario, each checking
// its own results against a model written from the requirements.
module sim_fused_pair_alu;
    localparam int W = 32;
    localparam int IMM_W = 16;
    localparam int TAG_W = 5;

    typedef struct {
        logic [3:0]       hop;
        logic [3:0]       top;
        logic             uimm;
        logic [1:0]       tsrc;
        logic [W-1:0]     a, b, c;
        logic [IMM_W-1:0] imm;
        logic [TAG_W-1:0] htag, ttag;
        logic             hwen, twen;
    } mop_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    mop_t cur;
    logic out_valid, out_head_we, out_tail_we, out_br_taken, out_illegal;
    logic [TAG_W-1:0] out_head_tag, out_tail_tag;
    logic [W-1:0] out_head_data, out_tail_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fused_pair_alu #(.W(W), .IMM_W(IMM_W), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_head_op(cur.hop), .in_tail_op(cur.top), .in_head_use_imm(cur.uimm),
        .in_tail_src(cur.tsrc), .in_src_a(cur.a), .in_src_b(cur.b), .in_src_c(cur.c),
        .in_imm(cur.imm), .in_head_tag(cur.htag), .in_tail_tag(cur.ttag),
        .in_head_wen(cur.hwen), .in_tail_wen(cur.twen),
        .out_valid(out_valid), .out_head_we(out_head_we), .out_head_tag(out_head_tag),
        .out_head_data(out_head_data), .out_tail_we(out_tail_we), .out_tail_tag(out_tail_tag),
        .out_tail_data(out_tail_data), .out_br_taken(out_br_taken), .out_illegal(out_illegal)
    );

    task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic mop_t mk(input logic [3:0] hop, input logic [3:0] top, input logic uimm,
                                input logic [1:0] tsrc, input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic [W-1:0] c, input logic [IMM_W-1:0] imm);
        mop_t m;
        m.hop = hop; m.top = top; m.uimm = uimm; m.tsrc = tsrc;
        m.a = a; m.b = b; m.c = c; m.imm = imm;
        m.htag = 5'd3; m.ttag = 5'd17; m.hwen = 1'b1; m.twen = 1'b1;
        return m;
    endfunction

    // Compare the writeback slot against the requirement model.
    task automatic expect_out(input string req, input mop_t m);
        logic [W-1:0] ix, hb, h, oth, t;
        logic legal, test, tk;
        ix  = {{(W-IMM_W){m.imm[IMM_W-1]}}, m.imm};
        hb  = m.uimm ? ix : m.b;
        case (m.hop)
            4'd0: h = m.a + hb;  4'd1: h = m.a - hb;  4'd2: h = m.a & hb;
            4'd3: h = m.a | hb;  4'd4: h = m.a ^ hb;  default: h = '0;
        endcase
        case (m.tsrc)
            2'd0: oth = m.a; 2'd1: oth = m.b; 2'd2: oth = m.c; default: oth = ix;
        endcase
        test = (m.top == 4'd8) || (m.top == 4'd9) || (m.top == 4'd10);
        tk = 1'b0; t = '0;
        case (m.top)
            4'd0: t = h + oth;  4'd2: t = h & oth;  4'd3: t = h | oth;  4'd4: t = h ^ oth;
            4'd8: tk = (h == '0); 4'd9: tk = (h != '0); 4'd10: tk = h[W-1];
            default: t = '0;
        endcase
        legal = (m.hop <= 4'd4) && ((m.top == 4'd0) || (m.top == 4'd2) || (m.top == 4'd3) ||
                (m.top == 4'd4) || test) && !((m.tsrc == 2'd2) && !m.uimm);
        check(req, "valid", {31'd0, out_valid}, 32'd1);
        check(req, "illegal", {31'd0, out_illegal}, {31'd0, !legal});
        check(req, "head_we", {31'd0, out_head_we}, {31'd0, legal && m.hwen});
        check(req, "tail_we", {31'd0, out_tail_we}, {31'd0, legal && m.twen && !test});
        check(req, "taken", {31'd0, out_br_taken}, {31'd0, legal && test && tk});
        if (legal) begin
            check(req, "head_data", out_head_data, h);
            if (!test) check(req, "tail_data", out_tail_data, t);
            check(req, "head_tag", {27'd0, out_head_tag}, {27'd0, m.htag});
            check(req, "tail_tag", {27'd0, out_tail_tag}, {27'd0, m.ttag});
        end
    endtask

    // Single macro-op: no result after one edge, full result after two.
    task automatic run_one(input string req, input mop_t m);
        @(negedge clk); cur = m; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check("R2", "early valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk); expect_out(req, m);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1", "ready in reset", {31'd0, in_ready}, 32'd0);
        check("R1", "valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1", "head_we in reset", {31'd0, out_head_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_head_ops;
        run_one("R3", mk(4'd0, 4'd0, 1'b0, 2'd0, 32'h0000_1234, 32'h0000_0010, 32'h0, 16'h0));
        run_one("R3", mk(4'd1, 4'd0, 1'b0, 2'd1, 32'h0000_0005, 32'h0000_0009, 32'h0, 16'h0));
        run_one("R3", mk(4'd2, 4'd0, 1'b1, 2'd3, 32'hF0F0_FFFF, 32'h0, 32'h0, 16'h8F0F));
        run_one("R3", mk(4'd3, 4'd2, 1'b1, 2'd2, 32'h1200_0000, 32'h0, 32'h0FF0_00FF, 16'h00AA));
        run_one("R3", mk(4'd4, 4'd4, 1'b0, 2'd0, 32'hAAAA_5555, 32'hFFFF_0000, 32'h0, 16'h0));
    endtask

    task automatic t_collapse;
        // subtract head into add tail, carry across the full word
        run_one("R4", mk(4'd1, 4'd0, 1'b1, 2'd2, 32'h0000_0000, 32'h0, 32'h0000_0001, 16'h0001));
        run_one("R4", mk(4'd1, 4'd0, 1'b0, 2'd0, 32'hFFFF_FFFF, 32'h8000_0001, 32'h0, 16'h0));
        run_one("R4", mk(4'd0, 4'd0, 1'b1, 2'd3, 32'h7FFF_FFFF, 32'h0, 32'h0, 16'hFFFF));
        run_one("R4", mk(4'd2, 4'd3, 1'b0, 2'd1, 32'h1234_5678, 32'h0F0F_0F0F, 32'h0, 16'h0));
    endtask

    task automatic t_enables;
        mop_t m;
        m = mk(4'd0, 4'd0, 1'b1, 2'd2, 32'd10, 32'd0, 32'd20, 16'd5);
        m.hwen = 1'b0; m.htag = 5'd9; m.ttag = 5'd30;
        run_one("R5", m);
        m.hwen = 1'b1; m.twen = 1'b0; m.htag = 5'd31; m.ttag = 5'd0;
        run_one("R5", m);
    endtask

    task automatic t_tests;
        run_one("R6", mk(4'd1, 4'd8, 1'b0, 2'd0, 32'd77, 32'd77, 32'd0, 16'd0));
        run_one("R6", mk(4'd1, 4'd8, 1'b0, 2'd0, 32'd77, 32'd76, 32'd0, 16'd0));
        run_one("R6", mk(4'd4, 4'd9, 1'b0, 2'd0, 32'd5, 32'd4, 32'd0, 16'd0));
        run_one("R6", mk(4'd4, 4'd9, 1'b0, 2'd0, 32'd5, 32'd5, 32'd0, 16'd0));
        run_one("R6", mk(4'd1, 4'd10, 1'b1, 2'd0, 32'd3, 32'd0, 32'd0, 16'd4));
        run_one("R6", mk(4'd1, 4'd10, 1'b1, 2'd0, 32'd4, 32'd0, 32'd0, 16'd4));
    endtask

    task automatic t_illegal;
        run_one("R7", mk(4'd5, 4'd0, 1'b0, 2'd0, 32'd1, 32'd2, 32'd0, 16'd0));
        run_one("R7", mk(4'd0, 4'd1, 1'b0, 2'd0, 32'd1, 32'd2, 32'd0, 16'd0));
        run_one("R7", mk(4'd0, 4'd12, 1'b0, 2'd1, 32'd1, 32'd2, 32'd0, 16'd0));
        run_one("R8", mk(4'd0, 4'd0, 1'b0, 2'd2, 32'd1, 32'd2, 32'd3, 16'd0));
        run_one("R8", mk(4'd0, 4'd9, 1'b0, 2'd2, 32'd0, 32'd0, 32'd3, 16'd0));
    endtask

    task automatic t_back_to_back;
        mop_t m0, m1, m2;
        m0 = mk(4'd0, 4'd0, 1'b1, 2'd2, 32'd100, 32'd0, 32'd1, 16'd11);
        m1 = mk(4'd1, 4'd9, 1'b0, 2'd0, 32'd8, 32'd8, 32'd0, 16'd0);
        m2 = mk(4'd3, 4'd4, 1'b0, 2'd1, 32'h00FF, 32'hFF00, 32'd0, 16'd0);
        m1.htag = 5'd21; m2.ttag = 5'd6;
        @(negedge clk); cur = m0; in_valid = 1'b1;
        @(negedge clk); cur = m1;
        @(negedge clk); expect_out("R2", m0); cur = m2;
        @(negedge clk); expect_out("R2", m1); in_valid = 1'b0;
        @(negedge clk); expect_out("R2", m2);
        @(negedge clk);
        check("R2", "drain valid", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        cur = mk(4'd0, 4'd0, 1'b0, 2'd0, 32'd0, 32'd0, 32'd0, 16'd0);
        t_reset();
        t_head_ops();
        t_collapse();
        t_enables();
        t_tests();
        t_illegal();
        t_back_to_back();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule